// File: doc/BRIEF.md
# TLP Header Match-and-Patch Injector

This block sits in a PCIe transmit path between the header source and the link stage. Every outgoing transaction-layer header passes through a single register stage. When the first header dword matches a programmed mask and value, the block rewrites the masked bits of the second header dword with a programmed replacement value.

The patch is armed for an exact number of hits. A down-counter is decremented for each patched header that leaves the block, and patching stops when the counter reaches zero. The main use is repairing configuration-write byte enables: software computes the first byte enable from the access size and the low address bits, loads it into the replacement register, arms the counter with one, reads a register back as a fence, and then launches the access.

Configuration registers hold header bytes in reversed lane order relative to the header stream. A small write/read port loads the channel enables, the compare mask and value, the change mask and value, and the hit count.

Top module: `hdr_patch_inj`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and every configuration register reads back as 0.
- R2: Register reads return the value last written, one cycle after `reg_rd_en` is sampled. This includes the count register, which always reads back the programmed count and not the remaining hits. The register addresses are:
  - 0: enable
  - 1: compare mask
  - 2: compare value
  - 3: change mask
  - 4: change value
  - 5: count

  Unmapped addresses read 0.
- R3: Header byte k of a dword sits on stream bits [8k+7:8k], so the Fmt/Type byte is `in_hdr[7:0]`. Each compare and change register holds header byte k in register bits [31-8k:24-8k]. A header matches when (dword0 & M) == V, where M and V are the byte-swapped compare mask and compare value.
- R4: A patched header leaves with dword1 = (dword1 & ~C) | (W & C), where C and W are the byte-swapped change mask and change value. All other bits are unchanged.
- R5: A counter loaded by each count write is decremented only when a matched, patched header completes its output handshake. While the counter is 0, no header is patched.
- R6: Patching happens only while enable bit 6 is 1. The other enable bits are stored but have no effect on patching.
- R7: A header that does not match, or that is presented while the channel is disabled or the counter is 0, leaves bit-for-bit unchanged, including dword 2 and beyond.
- R8: The header path has one cycle of latency:
  - `in_ready` = !`out_valid` | `out_ready`.
  - A header accepted at a clock edge appears on the output after that edge.
  - A stalled output holds its value.
- R9: With compare mask 0xFE000000 and compare value 0x44000000, headers with Fmt/Type 0x44 and 0x45 match and 0x04 does not. With change mask 0xFF, the change value lands in `dword1[31:24]`, which holds the byte enables: last byte enable in bits [31:28], first byte enable in bits [27:24].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input header valid |
| in_ready | output | 1 | Block can take a header |
| in_hdr | input | HDR_DW*32 | Input header, dword 0 in bits [31:0] |
| out_valid | output | 1 | Output header valid |
| out_ready | input | 1 | Downstream takes the header |
| out_hdr | output | HDR_DW*32 | Output header, possibly patched |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 3 | Register write address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | 3 | Register read address |
| reg_rd_data | output | 32 | Register read data, one cycle after the strobe |

## Verification
The bench goes after the following corner cases, each of which a faulty design would expose:
- **Exhausted counter.** Further matching headers must pass untouched. A design that counts at input acceptance, or counts while stalled, would patch one header too many or too few.
- **Lane order.** A compare mask placed in the low register byte must hit the top header byte. A design without the byte swap would match the wrong byte and patch configuration reads or miss writes.
- **Partial change mask.** A mask covering only the first byte enable must keep the last byte-enable bits that were already there. A design that writes the whole byte would lose them.
- **Disabled channel.** Enabling every channel except channel 6 must leave headers unchanged.

// File: rtl/hpi_pkg.sv
package hpi_pkg;

   localparam int unsigned REG_W  = 32;
   localparam int unsigned REG_AW = 3;

   localparam logic [REG_AW-1:0] A_ENABLE   = 3'd0;
   localparam logic [REG_AW-1:0] A_CMP_MASK = 3'd1;
   localparam logic [REG_AW-1:0] A_CMP_VAL  = 3'd2;
   localparam logic [REG_AW-1:0] A_CHG_MASK = 3'd3;
   localparam logic [REG_AW-1:0] A_CHG_VAL  = 3'd4;
   localparam logic [REG_AW-1:0] A_COUNT    = 3'd5;

   // Compare and change settings, already in header lane order
   typedef struct packed {
      logic [REG_W-1:0] cmp_mask;
      logic [REG_W-1:0] cmp_val;
      logic [REG_W-1:0] chg_mask;
      logic [REG_W-1:0] chg_val;
   } hpi_cfg_t;

   // Register byte k <-> header byte (3-k)
   function automatic logic [REG_W-1:0] lane_swap(input logic [REG_W-1:0] v);
      logic [REG_W-1:0] r;
      for (int k = 0; k < REG_W/8; k++)
         r[8*k +: 8] = v[REG_W-8-8*k +: 8];
      return r;
   endfunction

endpackage

// File: rtl/hpi_regs.sv
module hpi_regs
   import hpi_pkg::*;
#(
   parameter int unsigned NUM_CH   = 8,
   parameter int unsigned PATCH_CH = 6,
   parameter int unsigned CNT_W    = 8,
   parameter bit          RD_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              rd_en,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   output hpi_cfg_t          cfg,
   output logic              ch_en,
   output logic              armed,
   input  logic              consume
);

   logic [NUM_CH-1:0] en_q;
   logic [REG_W-1:0]  cm_q, cv_q, gm_q, gv_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  rem_q;
   logic [REG_W-1:0]  rd_mux;
   logic              cnt_wr;

   assign cnt_wr = wr_en && (wr_addr == A_COUNT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         cm_q  <= '0;
         cv_q  <= '0;
         gm_q  <= '0;
         gv_q  <= '0;
         cnt_q <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_ENABLE:   en_q  <= wr_data[NUM_CH-1:0];
            A_CMP_MASK: cm_q  <= wr_data;
            A_CMP_VAL:  cv_q  <= wr_data;
            A_CHG_MASK: gm_q  <= wr_data;
            A_CHG_VAL:  gv_q  <= wr_data;
            A_COUNT:    cnt_q <= wr_data[CNT_W-1:0];
            default:    ;
         endcase
      end
   end

   // Remaining-hit counter; a count write re-arms and wins over a decrement
   always_ff @(posedge clk) begin
      if (!rst_n)
         rem_q <= '0;
      else if (cnt_wr)
         rem_q <= wr_data[CNT_W-1:0];
      else if (consume && (rem_q != '0))
         rem_q <= rem_q - CNT_W'(1);
   end

   always_comb begin
      case (rd_addr)
         A_ENABLE:   rd_mux = REG_W'(en_q);
         A_CMP_MASK: rd_mux = cm_q;
         A_CMP_VAL:  rd_mux = cv_q;
         A_CHG_MASK: rd_mux = gm_q;
         A_CHG_VAL:  rd_mux = gv_q;
         A_COUNT:    rd_mux = REG_W'(cnt_q);
         default:    rd_mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               rd_data <= '0;
            else if (rd_en)
               rd_data <= rd_mux;
         end
      end else begin : g_rd_comb
         assign rd_data = rd_mux;
      end
   endgenerate

   assign cfg.cmp_mask = lane_swap(cm_q);
   assign cfg.cmp_val  = lane_swap(cv_q);
   assign cfg.chg_mask = lane_swap(gm_q);
   assign cfg.chg_val  = lane_swap(gv_q);
   assign ch_en        = en_q[PATCH_CH];
   assign armed        = (rem_q != '0);

   // R5
   rem_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_q == '0 && !cnt_wr) |=> (rem_q == '0));

   // R5
   rem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_wr && !consume) |=> $stable(rem_q));

endmodule

// File: rtl/hpi_match.sv
module hpi_match
   import hpi_pkg::*;
#(
   parameter int unsigned HDR_DW = 3,
   localparam int unsigned HW    = HDR_DW * REG_W
) (
   input  logic [HW-1:0] hdr_in,
   input  hpi_cfg_t      cfg,
   input  logic          active,
   output logic [HW-1:0] hdr_out,
   output logic          hit
);

   logic [REG_W-1:0] dw0, dw1, dw1_new;

   assign dw0     = hdr_in[0 +: REG_W];
   assign dw1     = hdr_in[REG_W +: REG_W];
   assign hit     = active && ((dw0 & cfg.cmp_mask) == cfg.cmp_val);
   assign dw1_new = (dw1 & ~cfg.chg_mask) | (cfg.chg_val & cfg.chg_mask);

   genvar d;
   generate
      for (d = 0; d < HDR_DW; d++) begin : g_dw
         if (d == 1) begin : g_patch
            assign hdr_out[d*REG_W +: REG_W] = hit ? dw1_new : dw1;
         end else begin : g_pass
            assign hdr_out[d*REG_W +: REG_W] = hdr_in[d*REG_W +: REG_W];
         end
      end
   endgenerate

endmodule

// File: rtl/hpi_stage.sv
module hpi_stage #(
   parameter int unsigned W = 96
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);

   logic         vld_q;
   logic [W-1:0] dat_q;

   assign in_ready  = !vld_q || out_ready;
   assign out_valid = vld_q;
   assign out_data  = dat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else if (in_valid && in_ready) begin
         vld_q <= 1'b1;
         dat_q <= in_data;
      end else if (out_ready) begin
         vld_q <= 1'b0;
      end
   end

   // R8
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

   // R8
   empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> in_ready);

endmodule

// File: rtl/hdr_patch_inj.sv
module hdr_patch_inj
   import hpi_pkg::*;
#(
   parameter int unsigned HDR_DW   = 3,
   parameter int unsigned NUM_CH   = 8,
   parameter int unsigned PATCH_CH = 6,
   parameter int unsigned CNT_W    = 8,
   parameter bit          RD_REG   = 1'b1,
   localparam int unsigned HW      = HDR_DW * REG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [HW-1:0]     in_hdr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [HW-1:0]     out_hdr,
   input  logic              reg_wr_en,
   input  logic [REG_AW-1:0] reg_wr_addr,
   input  logic [REG_W-1:0]  reg_wr_data,
   input  logic              reg_rd_en,
   input  logic [REG_AW-1:0] reg_rd_addr,
   output logic [REG_W-1:0]  reg_rd_data
);

   generate
      if (HDR_DW < 2) begin : g_bad_dw
         $error("HDR_DW must be at least 2");
      end
      if (NUM_CH < 1 || NUM_CH > REG_W) begin : g_bad_ch
         $error("NUM_CH must be 1..32");
      end
      if (PATCH_CH >= NUM_CH) begin : g_bad_pch
         $error("PATCH_CH must be below NUM_CH");
      end
      if (CNT_W < 1 || CNT_W > REG_W) begin : g_bad_cnt
         $error("CNT_W must be 1..32");
      end
   endgenerate

   hpi_cfg_t       cfg;
   logic           ch_en, armed, hit, consume;
   logic [HW-1:0]  held_hdr;

   hpi_regs #(
      .NUM_CH(NUM_CH), .PATCH_CH(PATCH_CH), .CNT_W(CNT_W), .RD_REG(RD_REG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .rd_en(reg_rd_en), .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
      .cfg(cfg), .ch_en(ch_en), .armed(armed), .consume(consume)
   );

   hpi_stage #(.W(HW)) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_hdr),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(held_hdr)
   );

   hpi_match #(.HDR_DW(HDR_DW)) u_match (
      .hdr_in(held_hdr), .cfg(cfg), .active(ch_en && armed),
      .hdr_out(out_hdr), .hit(hit)
   );

   assign consume = out_valid && out_ready && hit;

   // R4
   keep_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (((out_hdr[REG_W +: REG_W] ^ held_hdr[REG_W +: REG_W])
                      & ~cfg.chg_mask) == '0));

   // R7
   passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !(ch_en && armed)) |-> (out_hdr == held_hdr));

   // R7
   dw0_intact_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_hdr[0 +: REG_W] == held_hdr[0 +: REG_W]));

endmodule

// File: tb/hdr_patch_inj_tb.sv
module hdr_patch_inj_tb;

   localparam int PER = 10;
   localparam int HW  = 96;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [HW-1:0] in_hdr = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic [HW-1:0] out_hdr;
   logic          reg_wr_en = 1'b0;
   logic [2:0]    reg_wr_addr = '0;
   logic [31:0]   reg_wr_data = '0;
   logic          reg_rd_en = 1'b0;
   logic [2:0]    reg_rd_addr = '0;
   logic [31:0]   reg_rd_data;

   int checks = 0;
   int errors = 0;

   always #(PER/2) clk = ~clk;

   hdr_patch_inj u_dut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_hdr(in_hdr),
      .out_valid(out_valid), .out_ready(out_ready), .out_hdr(out_hdr),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_en(reg_rd_en), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data)
   );

   // ---------------- reference model ----------------
   logic [31:0]   m_reg [6];
   int            m_rem;
   logic          m_valid;
   logic [HW-1:0] m_held;
   logic [31:0]   m_rdata;
   logic [HW-1:0] obs [$];

   function automatic logic [31:0] sw(input logic [31:0] v);
      return {<<8{v}};
   endfunction

   function automatic bit m_hit(input logic [HW-1:0] h);
      return m_reg[0][6] && (m_rem > 0) &&
             ((h[31:0] & sw(m_reg[1])) == sw(m_reg[2]));
   endfunction

   function automatic logic [HW-1:0] m_out(input logic [HW-1:0] h);
      logic [HW-1:0] r = h;
      if (m_hit(h))
         r[63:32] = (h[63:32] & ~sw(m_reg[3])) | (sw(m_reg[4]) & sw(m_reg[3]));
      return r;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 6; i++) m_reg[i] = '0;
         m_rem = 0; m_valid = 0; m_held = '0; m_rdata = '0;
      end else begin
         bit ofire, ifire;
         ofire = m_valid && out_ready;
         ifire = in_valid && (!m_valid || out_ready);
         if (reg_rd_en) m_rdata = (reg_rd_addr < 6) ? m_reg[reg_rd_addr] : 32'h0;
         if (ofire && m_hit(m_held)) m_rem = m_rem - 1;
         if (reg_wr_en && reg_wr_addr < 6) begin
            case (reg_wr_addr)
               3'd0:    m_reg[0] = reg_wr_data & 32'hFF;
               3'd5:    begin m_reg[5] = reg_wr_data & 32'hFF; m_rem = int'(reg_wr_data & 32'hFF); end
               default: m_reg[reg_wr_addr] = reg_wr_data;
            endcase
         end
         if (ifire) begin m_held = in_hdr; m_valid = 1; end
         else if (ofire) m_valid = 0;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [HW-1:0] act, input logic [HW-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (rst_n) begin
            chk(out_valid == m_valid, "R8 out_valid", HW'(out_valid), HW'(m_valid));
            chk(in_ready == (!m_valid || out_ready), "R8 in_ready", HW'(in_ready), HW'(!m_valid || out_ready));
            if (m_valid)
               chk(out_hdr == m_out(m_held), "R4 out_hdr cycle", out_hdr, m_out(m_held));
            chk(reg_rd_data == m_rdata, "R2 rd_data cycle", HW'(reg_rd_data), HW'(m_rdata));
            if (out_valid && out_ready) obs.push_back(out_hdr);
         end
      end
   end

   // ---------------- tasks ----------------
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr_en = 1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      reg_rd_en = 1; reg_rd_addr = a;
      @(negedge clk);
      reg_rd_en = 0;
      #2 v = reg_rd_data;
   endtask

   task automatic send(input logic [HW-1:0] h);
      @(negedge clk);
      in_valid = 1; in_hdr = h;
      forever begin
         #2;
         if (in_ready) begin @(posedge clk); break; end
         @(negedge clk);
      end
      @(negedge clk);
      in_valid = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_obs(input string tag, input logic [HW-1:0] exp);
      logic [HW-1:0] a;
      idle(3);
      if (obs.size() == 0) chk(0, tag, '0, exp);
      else begin a = obs.pop_front(); chk(a == exp, tag, a, exp); end
   endtask

   localparam logic [31:0] DW0_WR0 = 32'h0100_0044;
   localparam logic [31:0] DW0_WR1 = 32'h0100_0045;
   localparam logic [31:0] DW0_RD0 = 32'h0100_0004;
   localparam logic [31:0] DW2     = 32'h0000_0108;

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      #1;
      chk(out_valid == 0, "R1 out_valid reset", HW'(out_valid), 0);
      chk(in_ready == 1, "R1 in_ready reset", HW'(in_ready), 1);
      rst_n = 1;
      for (int a = 0; a < 6; a++) begin
         rd(3'(a), v);
         chk(v == 0, "R1 reg reset value", HW'(v), 0);
      end

      // program the byte-enable repair: 2-byte write at addr&3 = 2 -> FBE 0xC
      wr(3'd0, 32'h40);
      wr(3'd1, 32'hFE00_0000);
      wr(3'd2, 32'h4400_0000);
      wr(3'd3, 32'h0000_00FF);
      wr(3'd4, 32'h0000_000C);
      wr(3'd5, 32'h1);
      rd(3'd1, v); chk(v == 32'hFE00_0000, "R2 cmp mask readback", HW'(v), HW'(32'hFE00_0000));
      rd(3'd2, v); chk(v == 32'h4400_0000, "R2 cmp val readback", HW'(v), HW'(32'h4400_0000));
      rd(3'd4, v); chk(v == 32'hC, "R2 chg val readback", HW'(v), HW'(32'hC));
      rd(3'd6, v); chk(v == 0, "R2 unmapped read", HW'(v), 0);

      send({DW2, 32'h0011_2233, DW0_WR0});
      expect_obs("R9 cfg write patched", {DW2, 32'h0C11_2233, DW0_WR0});
      send({DW2, 32'h0011_2233, DW0_WR0});
      expect_obs("R5 count exhausted", {DW2, 32'h0011_2233, DW0_WR0});

      // re-arm with 2: type 1 write matches, read does not
      wr(3'd5, 32'h2);
      send({DW2, 32'hF011_2233, DW0_WR1});
      expect_obs("R9 type1 write patched", {DW2, 32'h0C11_2233, DW0_WR1});
      send({DW2, 32'h0011_2233, DW0_RD0});
      expect_obs("R3 cfg read not matched", {DW2, 32'h0011_2233, DW0_RD0});
      send({DW2, 32'h0011_2233, DW0_WR0});
      expect_obs("R5 second hit patched", {DW2, 32'h0C11_2233, DW0_WR0});
      send({DW2, 32'h0011_2233, DW0_WR0});
      expect_obs("R7 passthrough at zero", {DW2, 32'h0011_2233, DW0_WR0});
      rd(3'd5, v); chk(v == 2, "R2 count reads programmed value", HW'(v), 2);

      // other channels only
      wr(3'd0, 32'hBF);
      wr(3'd5, 32'h3);
      send({DW2, 32'h0011_2233, DW0_WR0});
      expect_obs("R6 other enables no effect", {DW2, 32'h0011_2233, DW0_WR0});
      rd(3'd0, v); chk(v == 32'hBF, "R2 enable readback", HW'(v), HW'(32'hBF));
      wr(3'd0, 32'h40);
      send({DW2, 32'h0011_2233, DW0_WR0});
      expect_obs("R6 channel enabled", {DW2, 32'h0C11_2233, DW0_WR0});

      // backpressure: count 1, stall output several cycles
      wr(3'd5, 32'h1);
      @(negedge clk); out_ready = 0;
      send({DW2, 32'h0011_2233, DW0_WR0});
      #2;
      chk(out_valid == 1, "R8 latency one cycle", HW'(out_valid), 1);
      chk(in_ready == 0, "R8 stalled not ready", HW'(in_ready), 0);
      idle(4);
      @(negedge clk); out_ready = 1;
      expect_obs("R8 stalled header patched once", {DW2, 32'h0C11_2233, DW0_WR0});
      send({DW2, 32'h0011_2233, DW0_WR0});
      expect_obs("R5 no extra hit after stall", {DW2, 32'h0011_2233, DW0_WR0});

      // partial change mask: only FBE bits
      wr(3'd3, 32'h0000_000F);
      wr(3'd4, 32'h0000_00F5);
      wr(3'd5, 32'h1);
      send({DW2, 32'hA011_2233, DW0_WR0});
      expect_obs("R4 partial mask keeps LBE", {DW2, 32'hA511_2233, DW0_WR0});

      // lane order: low register byte compares header byte 3
      wr(3'd1, 32'h0000_00FF);
      wr(3'd2, 32'h0000_0001);
      wr(3'd3, 32'h0000_00FF);
      wr(3'd4, 32'h0000_0003);
      wr(3'd5, 32'h1);
      send({DW2, 32'h0011_2233, DW0_RD0});
      expect_obs("R3 lane order match", {DW2, 32'h0311_2233, DW0_RD0});

      // streaming with toggling backpressure, checked every cycle by the model
      wr(3'd1, 32'hFE00_0000);
      wr(3'd2, 32'h4400_0000);
      wr(3'd5, 32'h3);
      fork
         for (int i = 0; i < 8; i++) send({DW2 + 32'(i), 32'h0011_2233, (i % 2) ? DW0_RD0 : DW0_WR0});
         for (int j = 0; j < 40; j++) begin @(negedge clk); out_ready = (j % 3) != 1; end
      join
      @(negedge clk); out_ready = 1;
      idle(4);
      chk(obs.size() == 8, "R7 stream count", HW'(obs.size()), 8);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog R8: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule